// File: doc/BRIEF.md
# Key-Combination Hold Reset Generator

This block watches a vector of event states and drives two reset lines. Each line is armed by a small set of programmed event slots. A slot names one event source by a 7-bit code and says which level of that source counts. When every armed slot of a line is satisfied at once, and stays satisfied for a programmed hold time, the line asserts. It stays asserted while the combination is held and releases as soon as the combination breaks.

The event sources are key presses and general input or logic states. Codes up to a parameterised boundary are keys; codes above it are general inputs. Hold time is counted in ticks of an external periodic time base. It is set by a 3-bit code that both lines share. Each line has its own output polarity. The first line can also follow an external reset request when the passthrough enable is set.

All configuration arrives as parallel inputs. No data stream passes through the block, so every pin is a plain level or pulse and there is no handshake.

Top module: `keyhold_rst_gen`

## Requirements
- R1: Line A has three slots and line B has two. Slot k of a line is bits [8k+7:8k] of that line's slot bus, with the event code in bits [6:0] and the level bit in bit 7. A slot whose code is 0 is disabled and takes no part in the combination.
- R2: A line whose slots are all disabled never asserts from its combination, whatever the event states are.
- R3: A line's combination is true only when every enabled slot is satisfied in the same cycle. If any one enabled slot is unsatisfied, the line does not assert.
- R4: Codes 1 to KEY_LAST are keys. A key slot is satisfied only when its level bit is 1 and the event bit is 1, so a key slot with level 0 is never satisfied. A slot with a code above KEY_LAST is satisfied when its event bit equals its level bit.
- R5: With hold code 0, a line asserts at the first clock edge at which its combination is true. With hold code c from 1 to 7, the line asserts at the edge that samples the ((c+1)*TICKS_PER_STEP)-th tick while the combination is held without a break. One hold code serves both lines.
- R6: While the combination stays true, an asserted line stays asserted. At the first edge that samples the combination false, the line deasserts and its tick count restarts from zero.
- R7: Polarity bit 0 drives a line low when asserted and high when idle. Polarity bit 1 drives the opposite levels.
- R8: When the passthrough enable is 1, the external reset input is ORed into line A without a clock delay. It never affects line B. When the enable is 0, the external input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse from the hold-time base |
| evt_state | input | 128 | Event states indexed by code; bit 0 is unused |
| slots_a | input | 24 | Three slot words for line A |
| slots_b | input | 16 | Two slot words for line B |
| hold_code | input | 3 | Shared hold-time code |
| pol_a | input | 1 | Polarity of line A |
| pol_b | input | 1 | Polarity of line B |
| pass_en | input | 1 | Enables the external reset on line A |
| ext_rst | input | 1 | External reset request, active high |
| rst_a_o | output | 1 | Reset line A |
| rst_b_o | output | 1 | Reset line B |

## Verification
The hardest case to reach from the ports is a broken hold: the combination drops one tick short of the target and then returns. A correct design must then demand a full fresh count. The stimulus issues ticks one at a time under bench control. It stops one tick short of each target, checks that the line is still idle, and then adds the last tick. This is swept over every nonzero hold code, and it is repeated after a deliberate break that falls just before the target.

// File: rtl/keyhold_pkg.sv
package keyhold_pkg;

  localparam int unsigned MAX_HOLD_STEPS = 8;

  function automatic int unsigned hold_target(input logic [2:0] code, input int unsigned tps);
    return (int'(code) + 1) * tps;
  endfunction

endpackage

// File: rtl/keyhold_slot_match.sv
module keyhold_slot_match #(
  parameter int CODE_W   = 7,
  parameter int KEY_LAST = 88
) (
  input  logic [CODE_W:0]         slot,
  input  logic [(1<<CODE_W)-1:0]  evt,
  output logic                    en,
  output logic                    sat
);
  localparam logic [CODE_W-1:0] KEY_MAX = CODE_W'(KEY_LAST);

  logic [CODE_W-1:0] code;
  logic              level;
  logic              is_key;
  logic              bit_now;

  always_comb begin
    code    = slot[CODE_W-1:0];
    level   = slot[CODE_W];
    en      = (code != '0);
    is_key  = (code <= KEY_MAX);
    bit_now = evt[code];
    if (!en)
      sat = 1'b0;
    else if (is_key)
      sat = level & bit_now;
    else
      sat = (bit_now == level);
  end
endmodule

// File: rtl/keyhold_combo.sv
module keyhold_combo #(
  parameter int NSLOT    = 3,
  parameter int CODE_W   = 7,
  parameter int KEY_LAST = 88
) (
  input  logic [NSLOT*(CODE_W+1)-1:0] slots,
  input  logic [(1<<CODE_W)-1:0]      evt,
  output logic                        any_en,
  output logic                        cond
);
  localparam int SLOT_W = CODE_W + 1;

  logic [NSLOT-1:0] en_v;
  logic [NSLOT-1:0] sat_v;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    keyhold_slot_match #(.CODE_W(CODE_W), .KEY_LAST(KEY_LAST)) u_match (
      .slot (slots[k*SLOT_W +: SLOT_W]),
      .evt  (evt),
      .en   (en_v[k]),
      .sat  (sat_v[k])
    );
  end

  always_comb begin
    any_en = |en_v;
    cond   = any_en & (&(sat_v | ~en_v));
  end
endmodule

// File: rtl/keyhold_timer.sv
module keyhold_timer #(
  parameter int TPS   = 500,
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cond,
  input  logic [2:0] hold_code,
  output logic       active
);
  import keyhold_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    target = CNT_W'(hold_target(hold_code, TPS));
    cnt_nx = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (!cond) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (!active) begin
      if (hold_code == 3'd0) begin
        active <= 1'b1;
      end else if (tick) begin
        cnt <= cnt_nx;
        if (cnt_nx >= target) active <= 1'b1;
      end
    end
  end

  AST_BREAK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !active); // R6
  AST_RISE_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(cond)); // R3
  AST_TIMED_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(hold_code) != 3'd0) |-> $past(tick)); // R5
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_HOLD_STEPS * TPS)); // R5
endmodule

// File: rtl/keyhold_rst_gen.sv
module keyhold_rst_gen #(
  parameter int CODE_W         = 7,
  parameter int KEY_LAST       = 88,
  parameter int SLOTS_A        = 3,
  parameter int SLOTS_B        = 2,
  parameter int TICKS_PER_STEP = 500
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [(1<<CODE_W)-1:0]        evt_state,
  input  logic [SLOTS_A*(CODE_W+1)-1:0] slots_a,
  input  logic [SLOTS_B*(CODE_W+1)-1:0] slots_b,
  input  logic [2:0]                    hold_code,
  input  logic                          pol_a,
  input  logic                          pol_b,
  input  logic                          pass_en,
  input  logic                          ext_rst,
  output logic                          rst_a_o,
  output logic                          rst_b_o
);
  localparam int CNT_W = $clog2(keyhold_pkg::MAX_HOLD_STEPS * TICKS_PER_STEP + 1);

  logic en_any_a, cond_a, act_a;
  logic en_any_b, cond_b, act_b;
  logic lvl_a;

  keyhold_combo #(.NSLOT(SLOTS_A), .CODE_W(CODE_W), .KEY_LAST(KEY_LAST)) u_combo_a (
    .slots (slots_a), .evt (evt_state), .any_en (en_any_a), .cond (cond_a)
  );
  keyhold_timer #(.TPS(TICKS_PER_STEP), .CNT_W(CNT_W)) u_timer_a (
    .clk (clk), .rst_n (rst_n), .tick (tick), .cond (cond_a),
    .hold_code (hold_code), .active (act_a)
  );

  keyhold_combo #(.NSLOT(SLOTS_B), .CODE_W(CODE_W), .KEY_LAST(KEY_LAST)) u_combo_b (
    .slots (slots_b), .evt (evt_state), .any_en (en_any_b), .cond (cond_b)
  );
  keyhold_timer #(.TPS(TICKS_PER_STEP), .CNT_W(CNT_W)) u_timer_b (
    .clk (clk), .rst_n (rst_n), .tick (tick), .cond (cond_b),
    .hold_code (hold_code), .active (act_b)
  );

  always_comb begin
    lvl_a   = act_a | (pass_en & ext_rst);
    rst_a_o = pol_a ? lvl_a : ~lvl_a;
    rst_b_o = pol_b ? act_b : ~act_b;
  end

  AST_A_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_en && ext_rst) |-> (rst_a_o == pol_a)); // R8
  AST_B_NO_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !act_b |-> (rst_b_o == !pol_b)); // R8
  AST_EMPTY_A_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_any_a |=> !act_a); // R2
  AST_EMPTY_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_any_b |=> !act_b); // R2
endmodule

// File: tb/keyhold_rst_gen_test.sv
module keyhold_rst_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [127:0] evt_state = '0;
  logic [23:0]  slots_a = '0;
  logic [15:0]  slots_b = '0;
  logic [2:0]   hold_code = '0;
  logic         pol_a = 1'b0, pol_b = 1'b0, pass_en = 1'b0, ext_rst = 1'b0;
  logic         rst_a_o, rst_b_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyhold_rst_gen #(.TICKS_PER_STEP(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_state(evt_state),
    .slots_a(slots_a), .slots_b(slots_b), .hold_code(hold_code),
    .pol_a(pol_a), .pol_b(pol_b), .pass_en(pass_en), .ext_rst(ext_rst),
    .rst_a_o(rst_a_o), .rst_b_o(rst_b_o)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic drive(input logic pol, input logic on);
    return pol ? on : ~on;
  endfunction

  task automatic clear_all();
    evt_state = '0; slots_a = '0; slots_b = '0; hold_code = '0;
    pass_en = 0; ext_rst = 0;
    step(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R7 reset idle A", rst_a_o, 1'b1);
    check("R7 reset idle B", rst_b_o, 1'b1);
    rst_n = 1'b1;
    step(2);

    // R2: no slot enabled, every event high
    evt_state = '1; step(4);
    check("R2 empty A", rst_a_o, drive(pol_a, 0));
    check("R2 empty B", rst_b_o, drive(pol_b, 0));
    clear_all();

    // R1 R5: code 0 immediate, slot 1 of A holds key 5
    slots_a[15:8] = {1'b1, 7'd5};
    evt_state[5] = 1; step();
    check("R5 immediate A", rst_a_o, drive(pol_a, 1));
    step(3);
    check("R6 held stays A", rst_a_o, drive(pol_a, 1));
    evt_state[5] = 0; step();
    check("R6 release A", rst_a_o, drive(pol_a, 0));
    clear_all();

    // R3 sweep: key5 lvl1, key6 lvl1, input 100 lvl0
    slots_a = {1'b0, 7'd100, 1'b1, 7'd6, 1'b1, 7'd5};
    for (int m = 0; m < 8; m++) begin
      evt_state[5] = m[0]; evt_state[6] = m[1]; evt_state[100] = ~m[2];
      step();
      check("R3 combo sweep", rst_a_o, drive(pol_a, m == 7));
      evt_state = '0; step();
    end
    clear_all();

    // R4: key slot with level 0 never satisfied
    slots_a[7:0] = {1'b0, 7'd5};
    evt_state[5] = 0; step(2);
    check("R4 key lvl0 released", rst_a_o, drive(pol_a, 0));
    evt_state[5] = 1; step(2);
    check("R4 key lvl0 pressed", rst_a_o, drive(pol_a, 0));
    // R4: general input levels
    slots_a[7:0] = {1'b1, 7'd100}; evt_state[100] = 1; step();
    check("R4 input lvl1 active", rst_a_o, drive(pol_a, 1));
    slots_a[7:0] = {1'b0, 7'd100}; evt_state[100] = 0; step();
    check("R4 input lvl0 inactive", rst_a_o, drive(pol_a, 1));
    evt_state[100] = 1; step();
    check("R4 input lvl0 active", rst_a_o, drive(pol_a, 0));
    clear_all();

    // R5 sweep of every nonzero hold code
    slots_a[23:16] = {1'b1, 7'd9};
    for (int c = 1; c < 8; c++) begin
      hold_code = 3'(c);
      evt_state[9] = 1;
      pulse_ticks((c + 1) * TPS - 1);
      step(2);
      check("R5 one tick short", rst_a_o, drive(pol_a, 0));
      pulse_ticks(1);
      check("R5 target reached", rst_a_o, drive(pol_a, 1));
      evt_state[9] = 0; step();
      check("R6 break drops", rst_a_o, drive(pol_a, 0));
    end

    // R6: break just before target restarts the count
    hold_code = 3'd2;
    evt_state[9] = 1; pulse_ticks(3 * TPS - 1);
    evt_state[9] = 0; step();
    evt_state[9] = 1; pulse_ticks(3 * TPS - 1);
    check("R6 count restarted", rst_a_o, drive(pol_a, 0));
    pulse_ticks(1);
    check("R6 full recount", rst_a_o, drive(pol_a, 1));
    clear_all();

    // R5 line B with shared code, two slots; R7 polarity high
    pol_a = 1; pol_b = 1; step();
    check("R7 idle high-pol A", rst_a_o, 1'b0);
    check("R7 idle high-pol B", rst_b_o, 1'b0);
    slots_b = {1'b1, 7'd101, 1'b1, 7'd7};
    hold_code = 3'd1;
    evt_state[7] = 1; step(); pulse_ticks(2 * TPS);
    check("R3 B one slot only", rst_b_o, 1'b0);
    evt_state[101] = 1; pulse_ticks(2 * TPS - 1);
    check("R5 B short", rst_b_o, 1'b0);
    pulse_ticks(1);
    check("R5 B fired", rst_b_o, 1'b1);
    check("R2 A untouched", rst_a_o, 1'b0);
    evt_state[101] = 0; step();
    check("R6 B release", rst_b_o, 1'b0);
    clear_all();

    // R8 passthrough
    ext_rst = 1; #1;
    check("R8 disabled no effect", rst_a_o, 1'b0);
    pass_en = 1; #1;
    check("R8 passthrough A", rst_a_o, 1'b1);
    check("R8 B unaffected", rst_b_o, 1'b0);
    pol_a = 0; pol_b = 0; #1;
    check("R8 passthrough low-pol A", rst_a_o, 1'b0);
    check("R8 B unaffected low-pol", rst_b_o, 1'b1);
    ext_rst = 0; #1;
    check("R8 release A", rst_a_o, 1'b1);
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule